// File: doc/BRIEF.md
# Selection Timeout Timer with Clock Prescaler

This block measures how long a selection or reselection attempt on a parallel peripheral bus has been waiting for an answer. The host programs an 8-bit timeout count and a 3-bit conversion factor. The conversion factor sets the length of one time unit as a multiple of the input clock. A one-cycle start strobe from the selection sequencer begins an attempt. A one-cycle stop strobe ends the attempt when the target answers. If the programmed number of time units passes without a stop, the block raises a one-cycle timeout pulse. That pulse feeds the interrupt bit that also reports a target disconnect.

One time unit lasts `UNIT_BASE` times the conversion factor in clock cycles, and `UNIT_BASE` defaults to 7682. The factor is normally chosen as the clock frequency in MHz plus four, divided by five and rounded down. It is never allowed below 2. The timeout count and the effective factor are captured when the attempt starts, so the host may reprogram them while an attempt is in flight.

Top module: `ssto_timer`

## Requirements
- R1: After reset, `tmo_pulse` is low. The timeout register resets to 0 and the factor register resets to 0, so an attempt started with no write lasts 256 units of 2×`UNIT_BASE` cycles.
- R2: When a start is sampled at clock edge E0 and no stop or start follows, `tmo_pulse` is high in exactly the cycle after edge E(T×F×`UNIT_BASE`). Here T is the timeout count and F is the effective factor. It is low in every earlier cycle of the attempt.
- R3: A timeout count of 0 means T = 256.
- R4: A factor written as 0 or 1 gives F = 2. Values 2 to 7 are used as written.
- R5: `tmo_pulse` is never high for two cycles in a row.
- R6: A stop sampled while an attempt runs cancels it, and no pulse follows. This holds even when the stop is sampled on the very edge where expiry would have occurred.
- R7: A start sampled during a running attempt restarts the full timeout from that edge.
- R8: A stop sampled after expiry has no effect and produces no pulse.
- R9: Register writes sampled during an attempt do not change that attempt's length. They take effect at the next start.
- R10: When start and stop are sampled on the same edge, the start wins and a new attempt begins.
- R11: Each attempt produces at most one pulse. With no new start, the output stays low after expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_we | input | 1 | Write strobe for the timeout count |
| tmo_wdata | input | 8 | Timeout count in time units, 0 means 256 |
| cf_we | input | 1 | Write strobe for the conversion factor |
| cf_wdata | input | 3 | Conversion factor, 0 and 1 behave as 2 |
| sel_start | input | 1 | One-cycle strobe that begins an attempt |
| sel_stop | input | 1 | One-cycle strobe that ends an attempt |
| tmo_pulse | output | 1 | One-cycle timeout indication |

## Verification
Each fault inside the block shows up as a shift in the position of the single timeout pulse:
- A prescaler that wraps at the wrong value moves the pulse by a multiple of the unit count.
- A unit counter that loads wrongly moves it by whole units.
- A faulty zero-count or factor clamp changes the pulse position by a large, distinctive factor.

These faults become visible at the first expiry after the faulty state is entered. The bench therefore measures the exact cycle of the pulse relative to the start edge. Control faults are different: a lost stop, a missed restart or a sticky output produce a pulse where none is expected, or a second pulse. The bench catches these by watching quiet windows well beyond the nominal expiry.

// File: rtl/ssto_pkg.sv
package ssto_pkg;
  localparam int TMO_W   = 8;
  localparam int CF_W    = 3;
  localparam int UNITS_W = TMO_W + 1;
  localparam int CF_MAX  = (1 << CF_W) - 1;
  localparam logic [CF_W-1:0] CF_FLOOR = CF_W'(2);

  // Effective conversion factor: values below the floor use the floor.
  function automatic logic [CF_W-1:0] eff_factor(input logic [CF_W-1:0] raw);
    return (raw < CF_FLOOR) ? CF_FLOOR : raw;
  endfunction

  // Unit count: a programmed zero stands for the full 2**TMO_W units.
  function automatic logic [UNITS_W-1:0] eff_units(input logic [TMO_W-1:0] raw);
    return (raw == '0) ? UNITS_W'(1 << TMO_W) : {1'b0, raw};
  endfunction
endpackage

// File: rtl/ssto_cfg_regs.sv
module ssto_cfg_regs
  import ssto_pkg::*;
#(
  parameter int UNIT_BASE = 7682,
  parameter int LEN_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tmo_we,
  input  logic [TMO_W-1:0]   tmo_wdata,
  input  logic               cf_we,
  input  logic [CF_W-1:0]    cf_wdata,
  input  logic               snap,
  output logic [LEN_W-1:0]   act_last,
  output logic [UNITS_W-1:0] act_units
);
  logic [TMO_W-1:0]   tmo_q, tmo_d;
  logic [CF_W-1:0]    cf_q, cf_d;
  logic [LEN_W-1:0]   last_q, last_d;
  logic [UNITS_W-1:0] units_q, units_d;
  int                 unit_len;

  always_comb begin
    tmo_d    = tmo_q;
    cf_d     = cf_q;
    last_d   = last_q;
    units_d  = units_q;
    unit_len = UNIT_BASE * int'(eff_factor(cf_q));
    if (tmo_we) tmo_d = tmo_wdata;
    if (cf_we)  cf_d  = cf_wdata;
    if (snap) begin
      last_d  = LEN_W'(unit_len - 1);
      units_d = eff_units(tmo_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q   <= '0;
      cf_q    <= '0;
      last_q  <= '0;
      units_q <= UNITS_W'(1);
    end else begin
      tmo_q   <= tmo_d;
      cf_q    <= cf_d;
      last_q  <= last_d;
      units_q <= units_d;
    end
  end

  assign act_last  = last_q;
  assign act_units = units_q;
endmodule

// File: rtl/ssto_prescaler.sv
module ssto_prescaler #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [LEN_W-1:0] last,
  output logic             tick,
  output logic [LEN_W-1:0] cnt
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick   = run && !clear && (cnt_q == last);
  assign cnt_en = clear || run;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ssto_unit_ctr.sv
module ssto_unit_ctr
  import ssto_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stop,
  input  logic               tick,
  input  logic [UNITS_W-1:0] units,
  output logic               run,
  output logic               expire,
  output logic [UNITS_W-1:0] cnt
);
  logic               run_q, run_d;
  logic               exp_q, exp_d;
  logic [UNITS_W-1:0] cnt_q, cnt_d;
  logic               last_unit;

  assign last_unit = (cnt_q == units - UNITS_W'(1));

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (stop) begin
      run_d = 1'b0;
    end else if (tick) begin
      if (last_unit) begin
        run_d = 1'b0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + UNITS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      exp_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      exp_q <= exp_d;
      cnt_q <= cnt_d;
    end
  end

  assign run    = run_q;
  assign expire = exp_q;
  assign cnt    = cnt_q;
endmodule

// File: rtl/ssto_timer.sv
module ssto_timer
  import ssto_pkg::*;
#(
  parameter int UNIT_BASE = 7682
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tmo_we,
  input  logic [7:0]  tmo_wdata,
  input  logic        cf_we,
  input  logic [2:0]  cf_wdata,
  input  logic        sel_start,
  input  logic        sel_stop,
  output logic        tmo_pulse
);
  localparam int MAX_LEN = UNIT_BASE * CF_MAX;
  localparam int LEN_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [LEN_W-1:0]   act_last;
  logic [UNITS_W-1:0] act_units;
  logic [LEN_W-1:0]   presc_cnt;
  logic [UNITS_W-1:0] unit_cnt;
  logic               run;
  logic               unit_tick;

  ssto_cfg_regs #(.UNIT_BASE(UNIT_BASE), .LEN_W(LEN_W)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .tmo_we(tmo_we), .tmo_wdata(tmo_wdata),
    .cf_we(cf_we), .cf_wdata(cf_wdata),
    .snap(sel_start),
    .act_last(act_last), .act_units(act_units)
  );

  ssto_prescaler #(.LEN_W(LEN_W)) presc_i (
    .clk(clk), .rst_n(rst_n),
    .clear(sel_start), .run(run), .last(act_last),
    .tick(unit_tick), .cnt(presc_cnt)
  );

  ssto_unit_ctr unit_i (
    .clk(clk), .rst_n(rst_n),
    .start(sel_start), .stop(sel_stop), .tick(unit_tick),
    .units(act_units),
    .run(run), .expire(tmo_pulse), .cnt(unit_cnt)
  );
endmodule

// File: rtl/ssto_timer_chk.sv
module ssto_timer_chk #(
  parameter int LEN_W   = 16,
  parameter int UNITS_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sel_start,
  input logic               sel_stop,
  input logic               tmo_pulse,
  input logic               run,
  input logic [LEN_W-1:0]   presc_cnt,
  input logic [LEN_W-1:0]   act_last,
  input logic [UNITS_W-1:0] unit_cnt,
  input logic [UNITS_W-1:0] act_units
);
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse);

  a_r6_stop_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_stop && !sel_start) |=> (!tmo_pulse && !run));

  a_r7_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    sel_start |=> (run && !tmo_pulse));

  a_r11_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sel_start) |=> !tmo_pulse);

  a_r11_pulse_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> !run);

  a_r2_presc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (presc_cnt <= act_last));

  a_r3_unit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (unit_cnt < act_units));
endmodule

bind ssto_timer ssto_timer_chk #(.LEN_W(LEN_W), .UNITS_W(ssto_pkg::UNITS_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .sel_start(sel_start), .sel_stop(sel_stop),
  .tmo_pulse(tmo_pulse), .run(run),
  .presc_cnt(presc_cnt), .act_last(act_last),
  .unit_cnt(unit_cnt), .act_units(act_units)
);

// File: tb/ssto_timer_tb_top.sv
module ssto_timer_tb_top;
  localparam int BASE = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tmo_we, cf_we, sel_start, sel_stop;
  logic [7:0] tmo_wdata;
  logic [2:0] cf_wdata;
  logic       tmo_pulse;

  int errs   = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ssto_timer #(.UNIT_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tmo_we(tmo_we), .tmo_wdata(tmo_wdata),
    .cf_we(cf_we), .cf_wdata(cf_wdata),
    .sel_start(sel_start), .sel_stop(sel_stop),
    .tmo_pulse(tmo_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic strobe(input bit s, input bit p);
    @(negedge clk); sel_start = s; sel_stop = p;
    @(negedge clk); sel_start = 1'b0; sel_stop = 1'b0;
  endtask

  task automatic write_regs(input int t, input int f);
    @(negedge clk); tmo_we = 1'b1; cf_we = 1'b1;
    tmo_wdata = 8'(t); cf_wdata = 3'(f);
    @(negedge clk); tmo_we = 1'b0; cf_we = 1'b0;
  endtask

  // Called at the sample point of cycle k0; rem = N - k0.
  task automatic expect_pulse_at(input int rem, input string req);
    int early = 0;
    for (int i = 1; i < rem; i++) begin
      @(negedge clk);
      if (tmo_pulse) early++;
    end
    chk(early == 0, req, "early pulse cycles", early, 0);
    @(negedge clk);
    chk(tmo_pulse == 1'b1, req, "pulse at expiry", int'(tmo_pulse), 1);
    @(negedge clk);
    chk(tmo_pulse == 1'b0, req, "pulse one cycle wide", int'(tmo_pulse), 0);
  endtask

  task automatic expect_quiet(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tmo_pulse) hits++;
    end
    chk(hits == 0, req, "unexpected pulse cycles", hits, 0);
  endtask

  task automatic t_reset_default;
    chk(tmo_pulse == 1'b0, "R1", "pulse after reset", int'(tmo_pulse), 0);
    strobe(1, 0);
    expect_pulse_at(256 * 2 * BASE, "R1");
  endtask

  task automatic t_basic;
    write_regs(4, 3); strobe(1, 0); expect_pulse_at(4 * 3 * BASE, "R2");
    write_regs(1, 7); strobe(1, 0); expect_pulse_at(1 * 7 * BASE, "R2");
  endtask

  task automatic t_clamp;
    write_regs(2, 1); strobe(1, 0); expect_pulse_at(2 * 2 * BASE, "R4");
    write_regs(2, 0); strobe(1, 0); expect_pulse_at(2 * 2 * BASE, "R4");
  endtask

  task automatic t_zero_count;
    write_regs(0, 5); strobe(1, 0); expect_pulse_at(256 * 5 * BASE, "R3");
  endtask

  task automatic t_stop;
    write_regs(3, 2);
    strobe(1, 0); expect_quiet(5, "R6"); strobe(0, 1);
    expect_quiet(40, "R6");
    // stop sampled on the edge where expiry would fall (N = 18)
    strobe(1, 0); expect_quiet(16, "R6"); strobe(0, 1);
    expect_quiet(40, "R6");
  endtask

  task automatic t_restart;
    write_regs(3, 2);
    strobe(1, 0); expect_quiet(9, "R7"); strobe(1, 0);
    expect_pulse_at(3 * 2 * BASE, "R7");
  endtask

  task automatic t_write_during;
    write_regs(2, 2);
    strobe(1, 0); expect_quiet(2, "R9");
    write_regs(5, 7);
    expect_pulse_at(2 * 2 * BASE - 4, "R9");
    strobe(1, 0); expect_pulse_at(5 * 7 * BASE, "R9");
  endtask

  task automatic t_both;
    write_regs(3, 2);
    strobe(1, 1); expect_pulse_at(3 * 2 * BASE, "R10");
  endtask

  task automatic t_after_expiry;
    write_regs(1, 2);
    strobe(1, 0); expect_pulse_at(2 * BASE, "R11");
    strobe(0, 1); expect_quiet(30, "R8");
    expect_quiet(60, "R11");
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tmo_we = 1'b0; cf_we = 1'b0;
    tmo_wdata = '0; cf_wdata = '0; sel_start = 1'b0; sel_stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_default();
    t_basic();
    t_clamp();
    t_zero_count();
    t_stop();
    t_restart();
    t_write_during();
    t_both();
    t_after_expiry();
    finish_run();
  end
endmodule